// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that lets a bus master read and write a 32-byte register array. It watches SCL and SDA, both already synchronised to the system clock. It recognises START, repeated START and STOP conditions and answers only to a fixed 7-bit device identifier. SDA is driven through an open-drain output enable, where 1 pulls the line low. The register array sits outside the block and is reached through a plain byte port. That port has a register index, a one-cycle write strobe with its write data, and a combinational read-data return for the indexed register.

A byte-wide register pointer, of which the low five bits are used, sets which register a data byte goes to or comes from. The pointer keeps its value between transactions. A master can therefore read from wherever the last transaction stopped. It can also select a register with a short write phase that carries only a register-address byte, then issue a repeated START and read from that register. Sequential writes and reads advance the pointer one register per byte and wrap from 31 back to 0.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe_o` is 0, `reg_we_o` is 0 and `reg_addr_o` is 0.
- R2: The first byte after a START is received MSB first. Its upper seven bits are the identifier 1101000 and its bit 0 selects the direction (0 = write, 1 = read), so the byte is 0xD0 for a write and 0xD1 for a read. When the identifier matches, the block pulls SDA low during the ninth SCL clock.
- R3: If any identifier bit differs, the block leaves SDA released in the ninth clock and in every later clock, and it issues no register write until the next START or STOP.
- R4: In a write, the byte after the identifier byte loads the pointer with its low five bits. Each following data byte is written to the register the pointer names, with `reg_we_o` high for exactly one clock. The block acknowledges every one of these bytes.
- R5: The pointer advances by one after each data byte, whether written or read, and goes from 31 to 0.
- R6: A read addressed right after a START sends first the register the pointer names, which is register 0 after reset. Bytes are sent MSB first.
- R7: A write phase that carries only a register-address byte, followed by a repeated START and a read identifier byte, makes the read begin at the register just selected. The block acknowledges all three bytes.
- R8: After each byte the block sends, it releases SDA for the ninth clock. It sends the next byte only if the master pulled SDA low in that clock. After a master NACK it keeps SDA released until the next START or STOP.
- R9: The block changes `sda_oe_o` only while SCL is low.
- R10: A START or STOP in the middle of a byte abandons that byte, and no write is issued for it. A START begins a new identifier byte and a STOP returns the block to idle.
- R11: The pointer keeps its value across STOP, and across transactions that were not addressed to the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_addr_o | output | PTR_W | Register pointer, index into the register array |
| reg_we_o | output | 1 | One-clock write strobe |
| reg_wdata_o | output | 8 | Data written with the strobe |
| reg_rdata_i | input | 8 | Contents of the register selected by `reg_addr_o` |

## Verification
A wrong pointer value appears on `reg_addr_o` straight away. It also corrupts the next byte read back or the index of the next write strobe, so a reference pointer kept in the bench catches it at the first data byte. A phase or state error inside the controller shows up within one SCL clock: an acknowledge lands in the wrong clock, SDA is held low after a NACK or a mismatch, or an enable changes while SCL is high. The bench watches the enable every clock and checks every write strobe against a queue of expected writes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REGA,
    ST_REGA_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  // R10: a bus condition can never coincide with an SCL edge
  assert_cond_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det | stop_det) |-> !(scl_rise | scl_fall));
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ptr <= '0;
    else if (load | inc)      ptr <= ptr_d;
  end

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (ptr == {PTR_W{1'b1}})) |=> (ptr == '0));
  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(ptr));
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1101000,
  parameter int         PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rdata,
  output logic              ptr_load,
  output logic [PTR_W-1:0]  ptr_load_val,
  output logic              ptr_inc,
  output logic              we,
  output logic [BYTE_W-1:0] wdata,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tgt_state_e        state, state_d;
  logic [CNT_W-1:0]  bitcnt, bitcnt_d;
  logic [BYTE_W-1:0] sreg, sreg_d, tx, tx_d, byte_in;
  logic              half, half_d, rw, rw_d, mack, mack_d;
  logic              oe_d, we_d, inc_rd;

  assign byte_in = {sreg[BYTE_W-2:0], sda_i};

  always_comb begin
    state_d  = state;
    bitcnt_d = bitcnt;
    sreg_d   = sreg;
    tx_d     = tx;
    half_d   = half;
    rw_d     = rw;
    mack_d   = mack;
    oe_d     = sda_oe;
    we_d     = 1'b0;
    ptr_load = 1'b0;
    inc_rd   = 1'b0;
    if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      half_d   = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      half_d   = 1'b0;
      oe_d     = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_REGA, ST_WDATA: begin
          if (scl_rise) begin
            sreg_d   = byte_in;
            bitcnt_d = bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              half_d = 1'b0;
              if (state == ST_ADDR) begin
                if (byte_in[BYTE_W-1:1] == DEV_ID) begin
                  rw_d    = byte_in[0];
                  state_d = ST_ADDR_ACK;
                end else begin
                  state_d = ST_IGNORE;
                end
              end else if (state == ST_REGA) begin
                ptr_load = 1'b1;
                state_d  = ST_REGA_ACK;
              end else begin
                we_d    = 1'b1;
                state_d = ST_WDATA_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_REGA_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (!half) begin
              oe_d   = 1'b1;
              half_d = 1'b1;
            end else begin
              half_d   = 1'b0;
              bitcnt_d = '0;
              if (state == ST_ADDR_ACK && rw) begin
                state_d = ST_RDATA;
                tx_d    = rdata;
                oe_d    = ~rdata[BYTE_W-1];
              end else begin
                oe_d    = 1'b0;
                state_d = (state == ST_ADDR_ACK) ? ST_REGA : ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              inc_rd  = 1'b1;
              half_d  = 1'b0;
              state_d = ST_RDATA_ACK;
            end
          end else if (scl_fall) begin
            tx_d = {tx[BYTE_W-2:0], tx[BYTE_W-1]};
            oe_d = ~tx[BYTE_W-2];
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            half_d = 1'b1;
            mack_d = ~sda_i;
          end else if (scl_fall) begin
            if (!half) begin
              oe_d = 1'b0;
            end else begin
              half_d   = 1'b0;
              bitcnt_d = '0;
              if (mack) begin
                state_d = ST_RDATA;
                tx_d    = rdata;
                oe_d    = ~rdata[BYTE_W-1];
              end else begin
                state_d = ST_IGNORE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sreg   <= '0;
      tx     <= '0;
      half   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      we     <= 1'b0;
    end else begin
      state  <= state_d;
      bitcnt <= bitcnt_d;
      sreg   <= sreg_d;
      tx     <= tx_d;
      half   <= half_d;
      rw     <= rw_d;
      mack   <= mack_d;
      sda_oe <= oe_d;
      we     <= we_d;
    end
  end

  assign ptr_load_val = byte_in[PTR_W-1:0];
  assign ptr_inc      = inc_rd | we;
  assign wdata        = sreg;

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_i));
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
  // R3 and R8: the ignore state never drives the bus
  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe));
  assert_ack_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK && half) |-> sda_oe);
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ID = 7'b1101000,
  parameter int         PTR_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i
);
  logic rst_meta, rst_sync;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_inc;
  logic [PTR_W-1:0] ptr_load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  i2c_tgt_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_sync),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(.DEV_ID(DEV_ID), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .rdata        (reg_rdata_i),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .we           (reg_we_o),
    .wdata        (reg_wdata_o),
    .sda_oe       (sda_oe_o)
  );

  i2c_tgt_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .inc      (ptr_inc),
    .ptr      (reg_addr_o)
  );
endmodule

// File: tb/i2c_regfile_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regfile_target_tb_top;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_bus;
  logic       sda_oe_o, reg_we_o;
  logic [4:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic [7:0] mem [32];

  int checks = 0;
  int fails  = 0;
  int exp_mem [32];
  int exp_ptr = 0;
  int wq[$];
  logic prev_oe, prev_scl;

  always #10 clk = ~clk;

  assign sda_bus     = sda_m & ~sda_oe_o;
  assign reg_rdata_i = mem[reg_addr_o];

  i2c_regfile_target dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_we_o    (reg_we_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i)
  );

  always @(posedge clk) if (reg_we_o) mem[reg_addr_o] <= reg_wdata_o;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // every-clock comparison against the reference: write strobes and SDA timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we_o) begin
        if (wq.size() == 0) chk("R4 unexpected write", {reg_addr_o, reg_wdata_o}, -1);
        else chk("R4 write addr/data", {reg_addr_o, reg_wdata_o}, wq.pop_front());
      end
      if (sda_oe_o !== prev_oe) chk("R9 enable change with SCL low", prev_scl && scl_m, 0);
    end
    prev_oe  = sda_oe_o;
    prev_scl = scl_m;
  end

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
    ack = (sda_bus == 1'b0) ? 1 : 0;
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input int give_ack, output int b);
    b = 0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(); scl_m = 1'b1; hw(); b = (b << 1) | int'(sda_bus); scl_m = 1'b0;
    end
    sda_m = (give_ack != 0) ? 1'b0 : 1'b1;
    hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
  endtask

  task automatic write_regs(input int ra, input int data[$]);
    int ack;
    i2c_start();
    send_byte(8'hD0, ack); chk("R2 write id ack", ack, 1);
    send_byte(8'(ra), ack); chk("R4 reg-address ack", ack, 1);
    exp_ptr = ra % 32;
    foreach (data[i]) begin
      wq.push_back(exp_ptr * 256 + data[i]);
      send_byte(8'(data[i]), ack); chk("R4 data ack", ack, 1);
      exp_mem[exp_ptr] = data[i];
      exp_ptr = (exp_ptr + 1) % 32;
    end
    i2c_stop();
  endtask

  task automatic read_bytes(input string req, input int n);
    int b;
    for (int i = 0; i < n; i++) begin
      recv_byte((i < n - 1) ? 1 : 0, b);
      chk(req, b, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 32;
    end
  endtask

  task automatic read_cur(input string req, input int n);
    int ack;
    i2c_start();
    send_byte(8'hD1, ack); chk("R2 read id ack", ack, 1);
    read_bytes(req, n);
    i2c_stop();
  endtask

  task automatic read_rand(input string req, input int ra, input int n);
    int ack;
    i2c_start();
    send_byte(8'hD0, ack); chk("R7 dummy write id ack", ack, 1);
    send_byte(8'(ra), ack); chk("R7 reg-address ack", ack, 1);
    i2c_start();
    send_byte(8'hD1, ack); chk("R7 read id ack", ack, 1);
    exp_ptr = ra % 32;
    read_bytes(req, n);
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ack, b;
    for (int i = 0; i < 32; i++) begin
      mem[i]     = 8'((i * 37 + 11) % 256);
      exp_mem[i] = (i * 37 + 11) % 256;
    end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset oe", int'(sda_oe_o), 0);
    chk("R1 reset we", int'(reg_we_o), 0);
    chk("R1 reset ptr", int'(reg_addr_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after release", int'(sda_oe_o), 0);
    chk("R1 ptr after release", int'(reg_addr_o), 0);

    // R6: current-address read from reset pointer
    read_cur("R6 current read data", 2);
    chk("R5 ptr after read", int'(reg_addr_o), exp_ptr);

    // R4: sequential write, R11 pointer kept over STOP
    write_regs(5, '{8'hA1, 8'hB2, 8'hC3});
    repeat (20) @(negedge clk);
    chk("R11 ptr after write stop", int'(reg_addr_o), exp_ptr);
    read_cur("R11 read continues at ptr", 1);

    // R7: random read
    read_rand("R7 random read data", 6, 2);

    // R5: wrap on write and on read
    write_regs(31, '{8'h5A, 8'h6B});
    chk("R5 ptr wrap on write", int'(reg_addr_o), 1);
    read_rand("R5 read across wrap", 30, 4);

    // R4: only low five bits of register address used
    write_regs(8'hE3, '{});
    chk("R4 low five bits", int'(reg_addr_o), 3);

    // R3: identifier mismatch in last identifier bit
    i2c_start();
    send_byte(8'hD2, ack); chk("R3 no ack on mismatch", ack, 0);
    send_byte(8'h10, ack); chk("R3 ignored byte no ack", ack, 0);
    send_byte(8'h00, ack); chk("R3 ignored byte no ack", ack, 0);
    i2c_stop();
    chk("R3 ptr untouched", int'(reg_addr_o), 3);
    chk("R11 ptr after foreign transaction", int'(reg_addr_o), exp_ptr);

    // R8: master NACK stops transmission
    write_regs(8'h11, '{8'h00});
    read_rand("R8 single byte", 8'h10, 1);
    for (int i = 0; i < 9; i++) begin
      hw(); scl_m = 1'b1; hw();
      chk("R8 SDA released after NACK", int'(sda_bus), 1);
      scl_m = 1'b0;
    end
    i2c_stop();
    chk("R5 ptr after nack read", int'(reg_addr_o), 8'h11);

    // R10: STOP mid data byte drops the byte
    i2c_start();
    send_byte(8'hD0, ack); chk("R2 write id ack", ack, 1);
    send_byte(8'h08, ack); chk("R4 reg-address ack", ack, 1);
    exp_ptr = 8;
    send_bits(8'h00, 5);
    i2c_stop();
    repeat (20) @(negedge clk);
    chk("R10 no write on aborted byte", int'(reg_addr_o), 8);
    chk("R10 bus released after stop", int'(sda_oe_o), 0);

    // R10: START mid identifier restarts reception
    i2c_start();
    send_bits(8'hD0, 4);
    i2c_start();
    send_byte(8'hD1, ack); chk("R10 ack after restart", ack, 1);
    read_bytes("R10 read after restart", 1);
    i2c_stop();
    chk("R5 ptr after restart read", int'(reg_addr_o), exp_ptr);

    repeat (20) @(negedge clk);
    chk("R4 no pending writes", wq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule